// File: doc/BRIEF.md
# Command Word Initialization Sequencer

This block is the processor-facing register port of an interrupt controller. A host reaches it through a chip select, separate write and read strobes, one address bit and two byte-wide data buses. Writes are filtered so that a strobe counts only once. A write is then sorted into one of two kinds. The first kind is an ordered initialization series: a key word, then two to four words in total, where the key word's flags decide whether the third and fourth words are present. The second kind is a set of operation commands that the host may issue in any order once the series has finished.

The block remembers which word of the series it expects next. It raises `ready` once the last required word has arrived. It publishes every decoded configuration field to the priority datapath that sits beside it. It also returns a selected status or mask byte on reads, and gives an active-low enable for external bus buffers while a read is under way.

Top module: `cmdword_seq`

## Requirements
- R1: A write is taken only when `sel_n` and `wr_n` are both sampled low on two consecutive rising edges. The address and data are taken at the second of those edges. A strobe that is low on a single edge only is ignored.
- R2: A strobe held low for many cycles counts as one write. A further write is taken only after an edge at which the strobe was sampled inactive.
- R3: A write with `addr`=0 and data bit 4 = 1 starts a new series from any state. It drops `ready` and clears the word-2/3/4 fields. It captures data bit 0 as `need_w4`, bit 1 as `single_mode` and bit 3 as `trig_edge` (1 = edge requests).
- R4: After the key word, the next write with `addr`=1 is word 2, and `vec_base` takes its bits 7:3. A write with `addr`=0 and bit 4 = 0 during the series is ignored.
- R5: Word 3 (`cascade_cfg`) is expected only when `single_mode`=0. Word 4 (`mode_cfg`) is expected only when `need_w4`=1. `ready` goes high exactly at the edge that takes the last required word.
- R6: Reset leaves the block idle: `ready` and all configuration outputs are 0, the mask is 0, and reads at `addr`=0 select the request vector.
- R7: Once ready, an `addr`=1 write loads `mask`. Writes taken before `ready` never change `mask`.
- R8: Once ready, an `addr`=0 write with bit 4 = 0 and bit 3 = 0 updates `cmd2_data` and pulses `cmd2_stb` for one cycle.
- R9: Once ready, an `addr`=0 write with bit 4 = 0 and bit 3 = 1 is a read-select command. Bits 1:0 = 2'b10 select the request vector and 2'b11 select the in-service vector. Any other value keeps the current choice. That choice is shown on `rd_sel_isr` (1 = in-service).
- R10: `rdata` is registered. At the edge after `sel_n` and `rd_n` are sampled low, it shows `mask` for `addr`=1, or the selected vector for `addr`=0. It carries the value the mask had before any write taken at that same edge.
- R11: `rd_en_n` is low in exactly the cycles that follow an edge at which `sel_n` and `rd_n` were both sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 1 | Register select bit |
| wdata | input | DW | Write data |
| req_vec | input | DW | Request vector from the priority datapath |
| svc_vec | input | DW | In-service vector from the priority datapath |
| rdata | output | DW | Read data |
| rd_en_n | output | 1 | Active-low read buffer enable |
| ready | output | 1 | Initialization complete |
| trig_edge | output | 1 | 1 = edge-triggered requests |
| single_mode | output | 1 | Key word flag: no word 3 |
| need_w4 | output | 1 | Key word flag: word 4 follows |
| vec_base | output | DW-3 | Vector base from word 2 |
| cascade_cfg | output | DW | Word 3 contents |
| mode_cfg | output | DW | Word 4 contents |
| mask | output | DW | Mask register |
| cmd2_stb | output | 1 | One-cycle pulse on a second-command write |
| cmd2_data | output | DW | Last second-command byte |
| rd_sel_isr | output | 1 | Read-select state (1 = in-service) |

## Verification
The delicate overlap is a mask read and a mask write that are taken at the same rising edge. The bench holds the read and write strobes low together with `addr`=1. It then expects `rdata` to show the old mask in the cycle the write lands, and the new mask one edge later while the read is still held. A second overlap is a new key word that arrives while word 3 is still pending. That word must win over the pending step, and the bench judges it by the cleared fields and by the exact count of words needed before `ready` rises again.

// File: rtl/cwseq_pkg.sv
package cwseq_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE = 3'd0,
      SEQ_W2   = 3'd1,
      SEQ_W3   = 3'd2,
      SEQ_W4   = 3'd3,
      SEQ_RDY  = 3'd4
   } seq_st_t;

   localparam int KB_NEED4  = 0;
   localparam int KB_SINGLE = 1;
   localparam int KB_TRIG   = 3;
   localparam int KB_KEY    = 4;
   localparam int CB_SEL3   = 3;
   localparam int VB_LSB    = 3;
   localparam int MIN_DW    = 5;
endpackage

// File: rtl/cwseq_wrstrobe.sv
module cwseq_wrstrobe (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic wr_n,
   output logic fire
);
   logic act;
   logic act_q;
   logic armed_q;

   assign act  = ~sel_n & ~wr_n;
   assign fire = act & act_q & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         act_q <= act;
         if (!act)
            armed_q <= 1'b1;
         else if (fire)
            armed_q <= 1'b0;
      end
   end

   assert_one_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: rtl/cwseq_ctrl.sv
module cwseq_ctrl
   import cwseq_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic          ready,
   output logic          trig_edge,
   output logic          single_mode,
   output logic          need_w4,
   output logic [DW-4:0] vec_base,
   output logic [DW-1:0] cascade_cfg,
   output logic [DW-1:0] mode_cfg,
   output logic [DW-1:0] mask,
   output logic          cmd2_stb,
   output logic [DW-1:0] cmd2_data,
   output logic          rd_sel_isr
);
   localparam int VW = DW - VB_LSB;

   seq_st_t st_q, st_d;
   logic is_key, is_hi, is_cmd, is_c2, is_c3;
   logic last_after_w2, last_after_w3;

   assign is_key = fire & ~addr & wdata[KB_KEY];
   assign is_hi  = fire & addr;
   assign is_cmd = fire & ~addr & ~wdata[KB_KEY];
   assign is_c2  = is_cmd & ~wdata[CB_SEL3] & (st_q == SEQ_RDY);
   assign is_c3  = is_cmd &  wdata[CB_SEL3] & (st_q == SEQ_RDY);

   assign last_after_w2 = single_mode & ~need_w4;
   assign last_after_w3 = ~need_w4;

   always_comb begin
      st_d = st_q;
      if (is_key) begin
         st_d = SEQ_W2;
      end else if (is_hi) begin
         case (st_q)
            SEQ_W2:  st_d = last_after_w2 ? SEQ_RDY :
                            (single_mode ? SEQ_W4 : SEQ_W3);
            SEQ_W3:  st_d = last_after_w3 ? SEQ_RDY : SEQ_W4;
            SEQ_W4:  st_d = SEQ_RDY;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= SEQ_IDLE;
         trig_edge   <= 1'b0;
         single_mode <= 1'b0;
         need_w4     <= 1'b0;
         vec_base    <= '0;
         cascade_cfg <= '0;
         mode_cfg    <= '0;
         mask        <= '0;
         cmd2_stb    <= 1'b0;
         cmd2_data   <= '0;
         rd_sel_isr  <= 1'b0;
      end else begin
         st_q     <= st_d;
         cmd2_stb <= is_c2;
         if (is_key) begin
            trig_edge   <= wdata[KB_TRIG];
            single_mode <= wdata[KB_SINGLE];
            need_w4     <= wdata[KB_NEED4];
            vec_base    <= '0;
            cascade_cfg <= '0;
            mode_cfg    <= '0;
         end
         if (is_hi) begin
            case (st_q)
               SEQ_W2:  vec_base    <= wdata[DW-1:VB_LSB];
               SEQ_W3:  cascade_cfg <= wdata;
               SEQ_W4:  mode_cfg    <= wdata;
               SEQ_RDY: mask        <= wdata;
               default: ;
            endcase
         end
         if (is_c2)
            cmd2_data <= wdata;
         if (is_c3 && wdata[1])
            rd_sel_isr <= wdata[0];
      end
   end

   assign ready = (st_q == SEQ_RDY);

   logic [VW-1:0] unused_vw;
   assign unused_vw = '0;

   assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_key |=> (st_q == SEQ_W2) && !ready);
   assert_w3_needs_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_W3) |-> !single_mode);
   assert_ready_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(is_hi));
   assert_mask_only_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mask) |-> $past(st_q == SEQ_RDY));
   assert_stb_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd2_stb |-> $past(ready));
endmodule

// File: rtl/cwseq_rdmux.sv
module cwseq_rdmux #(
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_act,
   input  logic          addr,
   input  logic          sel_isr,
   input  logic [DW-1:0] req_vec,
   input  logic [DW-1:0] svc_vec,
   input  logic [DW-1:0] mask,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] pick;
   assign pick = addr ? mask : (sel_isr ? svc_vec : req_vec);

   generate
      if (RD_REG) begin : g_reg
         logic [DW-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata_q <= '0;
            else if (rd_act)
               rdata_q <= pick;
         end
         assign rdata = rdata_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ rd_act;
         assign rdata     = pick;
      end
   endgenerate
endmodule

// File: rtl/cmdword_seq.sv
module cmdword_seq
   import cwseq_pkg::*;
#(
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          wr_n,
   input  logic          rd_n,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] req_vec,
   input  logic [DW-1:0] svc_vec,
   output logic [DW-1:0] rdata,
   output logic          rd_en_n,
   output logic          ready,
   output logic          trig_edge,
   output logic          single_mode,
   output logic          need_w4,
   output logic [DW-4:0] vec_base,
   output logic [DW-1:0] cascade_cfg,
   output logic [DW-1:0] mode_cfg,
   output logic [DW-1:0] mask,
   output logic          cmd2_stb,
   output logic [DW-1:0] cmd2_data,
   output logic          rd_sel_isr
);
   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("cmdword_seq: DW must be at least 5");
      end
   endgenerate

   logic fire;
   logic rd_act;
   logic rd_en_q;

   assign rd_act = ~sel_n & ~rd_n;

   cwseq_wrstrobe u_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_n (sel_n),
      .wr_n  (wr_n),
      .fire  (fire)
   );

   cwseq_ctrl #(.DW(DW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .addr        (addr),
      .wdata       (wdata),
      .ready       (ready),
      .trig_edge   (trig_edge),
      .single_mode (single_mode),
      .need_w4     (need_w4),
      .vec_base    (vec_base),
      .cascade_cfg (cascade_cfg),
      .mode_cfg    (mode_cfg),
      .mask        (mask),
      .cmd2_stb    (cmd2_stb),
      .cmd2_data   (cmd2_data),
      .rd_sel_isr  (rd_sel_isr)
   );

   cwseq_rdmux #(.DW(DW), .RD_REG(RD_REG)) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_act  (rd_act),
      .addr    (addr),
      .sel_isr (rd_sel_isr),
      .req_vec (req_vec),
      .svc_vec (svc_vec),
      .mask    (mask),
      .rdata   (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_en_q <= 1'b0;
      else
         rd_en_q <= rd_act;
   end
   assign rd_en_n = ~rd_en_q;

   assert_rden_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_n |-> $past(!sel_n && !rd_n));
   assert_rden_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!sel_n && !rd_n) |-> !rd_en_n);
endmodule

// File: tb/tb_cmdword_seq.sv
`timescale 1ns/1ps
module tb_cmdword_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] req_vec = 8'hA5, svc_vec = 8'h3C;
   logic [7:0] rdata, cascade_cfg, mode_cfg, mask, cmd2_data;
   logic [4:0] vec_base;
   logic rd_en_n, ready, trig_edge, single_mode, need_w4, cmd2_stb, rd_sel_isr;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   cmdword_seq dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wdata(wdata), .req_vec(req_vec), .svc_vec(svc_vec),
      .rdata(rdata), .rd_en_n(rd_en_n), .ready(ready), .trig_edge(trig_edge),
      .single_mode(single_mode), .need_w4(need_w4), .vec_base(vec_base),
      .cascade_cfg(cascade_cfg), .mode_cfg(mode_cfg), .mask(mask),
      .cmd2_stb(cmd2_stb), .cmd2_data(cmd2_data), .rd_sel_isr(rd_sel_isr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d, output logic stb);
      @(negedge clk); sel_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      @(negedge clk); stb = cmd2_stb; sel_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_rd(input logic a, output logic [7:0] v);
      @(negedge clk); sel_n = 1'b0; rd_n = 1'b0; addr = a;
      @(negedge clk); v = rdata;
      chk(rd_en_n == 1'b0, "R11 rd_en_n low in read", rd_en_n, 0);
      sel_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      chk(rd_en_n == 1'b1, "R11 rd_en_n high after read", rd_en_n, 1);
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic s;
      logic [7:0] v;
      int pulses;
      repeat (3) @(negedge clk);
      // R6 reset state
      chk(ready == 0 && trig_edge == 0 && vec_base == 0 && mask == 0, "R6 reset outputs", ready, 0);
      chk(rd_en_n == 1, "R11 idle enable", rd_en_n, 1);
      rst_n = 1'b1;
      do_rd(1'b0, v); chk(v == 8'hA5, "R6 reset read select request", v, 8'hA5);
      do_rd(1'b1, v); chk(v == 8'h00, "R6 reset mask", v, 0);

      // R3 R4 R5 sweep of all key-word flag patterns
      for (int i = 0; i < 16; i++) begin
         logic [7:0] w2, w3, w4;
         logic sg, f4;
         w2 = 8'((i * 37 + 11) & 255);
         w3 = ~w2;
         w4 = w2 ^ 8'h5A;
         sg = i[1]; f4 = i[0];
         do_wr(1'b0, 8'(8'h10 | i), s);
         chk(ready == 0 && vec_base == 0, "R3 key word restarts", ready, 0);
         chk(trig_edge == i[3] && single_mode == sg && need_w4 == f4, "R3 flags captured",
             {trig_edge, single_mode, need_w4}, {i[3], sg, f4});
         do_wr(1'b0, 8'h00, s);
         chk(ready == 0 && s == 0 && cmd2_data == 0, "R4 command ignored in series", ready, 0);
         do_wr(1'b1, w2, s);
         chk(vec_base == w2[7:3], "R4 word2 vector base", vec_base, w2[7:3]);
         chk(ready == (sg && !f4), "R5 ready after word2", ready, sg && !f4);
         if (!sg) begin
            do_wr(1'b1, w3, s);
            chk(cascade_cfg == w3, "R5 word3 taken", cascade_cfg, w3);
            chk(ready == !f4, "R5 ready after word3", ready, !f4);
         end else begin
            chk(cascade_cfg == 0, "R5 word3 skipped", cascade_cfg, 0);
         end
         if (f4) begin
            do_wr(1'b1, w4, s);
            chk(mode_cfg == w4, "R5 word4 taken", mode_cfg, w4);
            chk(ready == 1, "R5 ready after word4", ready, 1);
         end
         chk(mask == 0, "R7 series leaves mask", mask, 0);
      end

      // R7 R10 mask sweep
      for (int k = 0; k < 9; k++) begin
         logic [7:0] m;
         m = (k == 8) ? 8'hC3 : 8'(1 << k);
         do_wr(1'b1, m, s);
         do_rd(1'b1, v);
         chk(v == m, "R7 R10 mask write and read", v, m);
      end

      // R8 second command
      do_wr(1'b0, 8'hE5, s);
      chk(s == 1 && cmd2_data == 8'hE5, "R8 command strobe and data", cmd2_data, 8'hE5);
      chk(cmd2_stb == 0, "R8 strobe one cycle", cmd2_stb, 0);

      // R9 read select
      do_wr(1'b0, 8'h0B, s);
      chk(s == 0 && rd_sel_isr == 1, "R9 select in-service", rd_sel_isr, 1);
      do_rd(1'b0, v); chk(v == 8'h3C, "R9 read in-service", v, 8'h3C);
      do_wr(1'b0, 8'h09, s);
      chk(rd_sel_isr == 1, "R9 other code keeps choice", rd_sel_isr, 1);
      do_wr(1'b0, 8'h0A, s);
      do_rd(1'b0, v); chk(v == 8'hA5, "R9 read request", v, 8'hA5);

      // R1 single-edge pulse ignored
      @(negedge clk); sel_n = 0; wr_n = 0; addr = 1; wdata = 8'hFF;
      @(negedge clk); sel_n = 1; wr_n = 1;
      @(negedge clk);
      do_rd(1'b1, v); chk(v == 8'hC3, "R1 short pulse ignored", v, 8'hC3);

      // R2 held strobe counts once
      pulses = 0;
      @(negedge clk); sel_n = 0; wr_n = 0; addr = 0; wdata = 8'h44;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk); if (cmd2_stb) pulses++;
      end
      sel_n = 1; wr_n = 1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); if (cmd2_stb) pulses++;
      end
      chk(pulses == 1, "R2 held strobe one write", pulses, 1);

      // R10 collision: read and write of mask at the same edge
      @(negedge clk); sel_n = 0; wr_n = 0; rd_n = 0; addr = 1; wdata = 8'h5E;
      @(negedge clk);
      @(negedge clk);
      chk(rdata == 8'hC3 && mask == 8'h5E, "R10 old mask on write edge", rdata, 8'hC3);
      wr_n = 1;
      @(negedge clk);
      chk(rdata == 8'h5E, "R10 new mask next edge", rdata, 8'h5E);
      sel_n = 1; rd_n = 1;
      @(negedge clk);

      // R3 restart while word3 pending
      do_wr(1'b0, 8'h10, s);
      do_wr(1'b1, 8'h80, s);
      chk(vec_base == 5'h10 && ready == 0, "R5 word3 pending", vec_base, 5'h10);
      do_wr(1'b0, 8'h19, s);
      chk(vec_base == 0 && trig_edge == 1 && ready == 0, "R3 restart mid series", vec_base, 0);
      do_wr(1'b1, 8'h48, s);
      do_wr(1'b1, 8'h77, s);
      chk(ready == 0, "R5 word4 still pending", ready, 0);
      do_wr(1'b1, 8'h99, s);
      chk(ready == 1 && cascade_cfg == 8'h77 && mode_cfg == 8'h99, "R5 restart complete", ready, 1);
      do_rd(1'b1, v); chk(v == 8'h5E, "R7 init words skip mask", v, 8'h5E);

      // R6 reset mid run
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk(ready == 0 && mask == 0 && rd_sel_isr == 0, "R6 reset mid run", ready, 0);
      rst_n = 1;
      do_wr(1'b1, 8'hFF, s);
      chk(mask == 0 && ready == 0, "R7 idle ignores mask write", mask, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule